// File: doc/BRIEF.md
# Serial Interrupt Bus Agent

This block is the device end of a single-wire, shared serial interrupt line. It keeps a set of local interrupt inputs in step with a host by reporting each one in its own time slot on the line. A cycle on the line opens with a start pulse held low. After the pulse rises, the agent counts three-clock data frames. In the slot that belongs to each of its inputs, it pulls the line low if that input is low. It then drives the line high for one clock to recover it, but only after it pulled the line low. In the third clock of the slot it lets the line go.

When a local input differs from the value last reported for it, the agent needs a new cycle. If a cycle is already running and the slot for that input has not yet come, the change simply goes out in that slot. If the slot has already passed, the change is held. Once the bus has been through its stop frame and is idle again, and the mode input selects quiet operation, the agent opens a cycle itself by pulling the line low for one clock. In continuous operation it never opens a cycle and waits for the host.

The line itself is outside the block. The agent sees it through `line_i` and controls it through two enables that a pad or a wired-AND model combines.

Top module: `sirq_agent`

## Requirements
- R1: While rst_ni is low, drv_low_o and drv_high_o are both 0.
- R2: Clock 0 is the first clock in which the line reads high after a start pulse. In clock 3n-1 after clock 0 (frame n, n = 1..NUM_IRQ), drv_low_o is 1 exactly when irq_i[n-1] is low. Otherwise both enables are 0.
- R3: In clock 3n, drv_high_o is 1 exactly when drv_low_o was 1 in the clock before. drv_low_o is 0.
- R4: In clock 1, and in every clock 3n+1, both enables are 0. The two enables are never 1 together.
- R5: Frame counting starts from the rising edge of the start pulse, whether the start pulse lasted 4, 5, 6 or 8 clocks. The first sample clock is clock 2.
- R6: With quiet_i = 1, an unreported input change while the bus is idle makes drv_low_o 1 for exactly one clock. The agent then stays off the line while the host holds the start pulse.
- R7: With quiet_i = 0, the agent never drives the line outside its data slots, whatever its inputs do.
- R8: A change that is synchronised before its own sample clock in a running cycle is reported in that cycle and does not cause a later start request.
- R9: A change that arrives after its slot's sample clock is reported with the old value in that cycle. A start request follows once the stop frame has ended and the line is idle.
- R10: Slots are reported the same way in cycles the host opened and in cycles the agent opened. A host-opened cycle clears any pending change it reports.
- R11: irq_i passes through a two-flop synchroniser. A change applied in clock c is first used in clock c+2, so an idle agent in quiet mode requests in clock c+3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | NUM_IRQ | Local interrupt levels; bit k is reported in frame k+1 |
| quiet_i | input | 1 | 1 = quiet mode (agent may open cycles), 0 = continuous mode (agent passive) |
| line_i | input | 1 | Present level of the shared serial line |
| drv_low_o | output | 1 | Enable to pull the line low |
| drv_high_o | output | 1 | Enable to drive the line high |

## Verification
The hardest case to reach is a change that lands after its own slot has passed while a cycle is still running. The agent must keep that change pending through the rest of the frames and through the stop frame, and only then request a new cycle. The bench gets there by changing two inputs together at clock 10 of a host-opened cycle. One input's slot is already past and one is still ahead. The bench expects the old value in slot 1, the new value in slot 16, and a one-clock pull low right after the stop frame. A further cycle must then clear the pending change, so the agent stays silent afterwards.

// File: rtl/sirq_agent_pkg.sv
package sirq_agent_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_KICK, ST_START, ST_FRAMES, ST_STOP_LO, ST_STOP_HI
  } bus_st_e;

  typedef enum logic [1:0] {
    PH_SAMPLE, PH_RECOV, PH_TURN
  } phase_e;
endpackage

// File: rtl/sirq_sync.sv
module sirq_sync #(
  parameter int          W       = 1,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= {W{RST_VAL}};
      sync_q <= {W{RST_VAL}};
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/sirq_frame_ctr.sv
module sirq_frame_ctr
  import sirq_agent_pkg::*;
#(
  parameter int NUM_FRAMES = 16,
  localparam int FW = $clog2(NUM_FRAMES + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          line_i,
  input  logic          kick_req_i,
  output logic          kick_o,
  output logic          sample_o,
  output logic          recov_o,
  output logic [FW-1:0] frame_o
);
  bus_st_e       st_q, st_d;
  phase_e        ph_q, ph_d;
  logic [FW-1:0] frame_q, frame_d;

  always_comb begin
    st_d    = st_q;
    ph_d    = ph_q;
    frame_d = frame_q;
    unique case (st_q)
      ST_IDLE: begin
        if (!line_i)         st_d = ST_START;
        else if (kick_req_i) st_d = ST_KICK;
      end
      ST_KICK:  st_d = ST_START;
      ST_START: begin
        if (line_i) begin
          // first high clock seen: next clock is clock 1, a turn-around
          st_d    = ST_FRAMES;
          ph_d    = PH_TURN;
          frame_d = '0;
        end
      end
      ST_FRAMES: begin
        if (ph_q == PH_TURN) begin
          if (frame_q == FW'(NUM_FRAMES)) st_d = ST_STOP_LO;
          else begin
            frame_d = frame_q + 1'b1;
            ph_d    = PH_SAMPLE;
          end
        end else if (ph_q == PH_SAMPLE) ph_d = PH_RECOV;
        else                            ph_d = PH_TURN;
      end
      ST_STOP_LO: if (!line_i) st_d = ST_STOP_HI;
      ST_STOP_HI: if (line_i)  st_d = ST_IDLE;
      default:    st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      ph_q    <= PH_TURN;
      frame_q <= '0;
    end else begin
      st_q    <= st_d;
      ph_q    <= ph_d;
      frame_q <= frame_d;
    end
  end

  assign kick_o   = (st_q == ST_KICK);
  assign sample_o = (st_q == ST_FRAMES) && (ph_q == PH_SAMPLE);
  assign recov_o  = (st_q == ST_FRAMES) && (ph_q == PH_RECOV);
  assign frame_o  = frame_q;

  p_kick_from_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_KICK) |-> ($past(st_q) == ST_IDLE && $past(kick_req_i)));

  p_count_on_rise_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(st_q == ST_FRAMES) |-> $past(line_i));
endmodule

// File: rtl/sirq_slot_drv.sv
module sirq_slot_drv #(
  parameter int NUM_IRQ = 16,
  localparam int FW = $clog2(NUM_IRQ + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_IRQ-1:0] irq_i,
  input  logic               sample_i,
  input  logic               recov_i,
  input  logic [FW-1:0]      frame_i,
  output logic               drv_low_o,
  output logic               drv_high_o,
  output logic               pend_o
);
  logic [NUM_IRQ-1:0] sel, rep_q;
  logic               drove_q;

  for (genvar k = 0; k < NUM_IRQ; k++) begin : g_slot
    assign sel[k] = sample_i && (frame_i == FW'(k + 1));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     rep_q[k] <= 1'b1;
      else if (sel[k]) rep_q[k] <= irq_i[k];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) drove_q <= 1'b0;
    else         drove_q <= drv_low_o;
  end

  assign drv_low_o  = |(sel & ~irq_i);
  assign drv_high_o = recov_i && drove_q;
  assign pend_o     = |(irq_i ^ rep_q);

  p_no_fight_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(drv_low_o && drv_high_o));

  p_high_needs_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drv_high_o |-> $past(drv_low_o));

  p_turn_release_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(recov_i) |-> !drv_high_o);
endmodule

// File: rtl/sirq_agent.sv
module sirq_agent #(
  parameter int NUM_IRQ = 16,
  localparam int FW = $clog2(NUM_IRQ + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_IRQ-1:0] irq_i,
  input  logic               quiet_i,
  input  logic               line_i,
  output logic               drv_low_o,
  output logic               drv_high_o
);
  logic [NUM_IRQ-1:0] irq_s;
  logic               kick, sample, recov, pend, slot_low;
  logic [FW-1:0]      frame;

  sirq_sync #(.W(NUM_IRQ), .RST_VAL(1'b1)) u_sync (
    .clk_i, .rst_ni, .d_i(irq_i), .q_o(irq_s)
  );

  sirq_frame_ctr #(.NUM_FRAMES(NUM_IRQ)) u_ctr (
    .clk_i, .rst_ni, .line_i,
    .kick_req_i(quiet_i && pend),
    .kick_o(kick), .sample_o(sample), .recov_o(recov), .frame_o(frame)
  );

  sirq_slot_drv #(.NUM_IRQ(NUM_IRQ)) u_slot (
    .clk_i, .rst_ni, .irq_i(irq_s),
    .sample_i(sample), .recov_i(recov), .frame_i(frame),
    .drv_low_o(slot_low), .drv_high_o(drv_high_o), .pend_o(pend)
  );

  assign drv_low_o = kick | slot_low;

  p_kick_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick |=> !drv_low_o);
endmodule

// File: tb/sirq_agent_bench.sv
module sirq_agent_bench;
  localparam int N    = 16;
  localparam int LAST = 3 * N + 1;

  typedef struct packed {
    logic [N-1:0] irq;
    logic [3:0]   low_clks;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{16'hFFFF, 4'd4}, '{16'h0000, 4'd8}, '{16'hA5A5, 4'd5},
    '{16'h7FFE, 4'd6}, '{16'h8001, 4'd4}, '{16'h3C3C, 4'd7}
  };

  logic         clk = 1'b0, rst_ni = 1'b0;
  logic [N-1:0] irq = '1;
  logic         quiet = 1'b0, host_en = 1'b0, host_val = 1'b1;
  logic         line, drv_low, drv_high;
  int           checks = 0, errors = 0;

  always #5 clk = ~clk;

  assign line = drv_low ? 1'b0 : (host_en ? host_val : 1'b1);

  sirq_agent #(.NUM_IRQ(N)) u_sirq_agent (
    .clk_i(clk), .rst_ni(rst_ni), .irq_i(irq), .quiet_i(quiet),
    .line_i(line), .drv_low_o(drv_low), .drv_high_o(drv_high)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // host opens a cycle, agent slots are checked clock by clock, host closes it
  task automatic host_run(input int low_clks, input logic [N-1:0] nv, input int chg_c);
    logic [N-1:0] ov = irq;
    @(posedge clk); #1 host_en = 1'b1; host_val = 1'b0;
    @(negedge clk);
    check("R6 silent in start", {drv_low, drv_high}, 0);
    repeat (low_clks - 1) @(posedge clk);
    @(posedge clk); #1 host_val = 1'b1;
    @(posedge clk); #1 host_en = 1'b0;
    for (int c = 1; c <= LAST; c++) begin
      int    sp, k;
      logic  v;
      logic [1:0] e;
      string rq;
      @(negedge clk);
      e  = 2'b00;
      rq = "R4";
      if ((c + 1) % 3 == 0 || (c % 3 == 0)) begin
        sp = ((c + 1) % 3 == 0) ? c : c - 1;
        k  = (sp + 1) / 3 - 1;
        v  = (chg_c > 0 && sp >= chg_c + 2) ? nv[k] : ov[k];
        if (sp == c) begin e = {!v, 1'b0}; rq = (c == 2) ? "R5" : "R2"; end
        else         begin e = {1'b0, !v}; rq = "R3"; end
      end
      check(rq, {drv_low, drv_high}, e);
      if (chg_c == c) irq = nv;
    end
    @(posedge clk); #1 host_en = 1'b1; host_val = 1'b0;
    @(posedge clk);
    @(posedge clk); #1 host_val = 1'b1;
    @(posedge clk); #1 host_en = 1'b0;
  endtask

  task automatic wait_kick(input int max, output int got);
    got = -1;
    for (int i = 0; i < max; i++) begin
      @(negedge clk);
      if (drv_low) begin got = i; break; end
    end
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog act=running exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int got, busy;
    repeat (3) @(negedge clk);
    check("R1 reset", {drv_low, drv_high}, 0);
    rst_ni = 1'b1;

    foreach (VECS[i]) begin
      irq  = VECS[i].irq;
      busy = 0;
      repeat (6) begin @(negedge clk); busy |= drv_low; end
      check("R7 passive", busy, 0);
      host_run(int'(VECS[i].low_clks), irq, 0);
    end

    quiet = 1'b1;
    @(negedge clk);
    irq = irq ^ 16'h0008;
    wait_kick(8, got);
    check("R11 kick clock", got, 2);
    host_run(4, irq, 0);
    wait_kick(12, got);
    check("R10 agent cycle cleared", got, -1);

    quiet = 1'b0;
    irq   = irq ^ 16'h0100;
    wait_kick(20, got);
    check("R7 no start", got, -1);
    host_run(5, irq, 0);
    quiet = 1'b1;
    wait_kick(12, got);
    check("R10 host cycle cleared", got, -1);

    host_run(6, irq ^ 16'h8001, 10);
    wait_kick(10, got);
    check("R9 late start", (got >= 0) ? 1 : 0, 1);
    host_run(4, irq, 0);
    wait_kick(12, got);
    check("R8 R9 settled", got, -1);

    rst_ni = 1'b0;
    @(negedge clk);
    check("R1 reset again", {drv_low, drv_high}, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule